// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block turns a four-bit binary code into a single asserted line among sixteen select outputs. The code passes through a strobe-controlled holding register. While the strobe is sampled high, the register follows the data inputs on each clock. While the strobe is low, the register keeps the last code it loaded. This lets a bus master present an address, close the strobe, and then reuse the data pins for other traffic.

A separate inhibit input drives every output to its idle level straight away. It does not disturb the held code. When inhibit is released, the previously held selection comes back at once. A parameter picks the output polarity: either the chosen line is high and the rest are low, or the chosen line is low and the rest are high. A typical use is a data distributor. The code addresses a destination, and the inhibit pin carries the serial bit that should appear on the addressed line.

Top module: `latched_decoder`

## Requirements
- R1: While `rst_n` is low, the held code is 0000. After reset is released with `strobe` low, line 0 is the addressed output.
- R2: On a rising clock edge where `strobe` is 1, the held code takes the value of `code_in`. The outputs show the new selection from that edge onward.
- R3: On a rising clock edge where `strobe` is 0, the held code keeps its value. Any change on `code_in` has no effect on `sel_out`.
- R4: The addressed line index equals the unsigned value of the held code, with `code_in[3]` as the most significant bit. Code 0000 addresses `sel_out[0]` and code 1111 addresses `sel_out[15]`.
- R5: With `ACTIVE_LOW` = 0, the addressed line is 1 and the other fifteen lines are 0.
- R6: With `ACTIVE_LOW` = 1, the addressed line is 0 and the other fifteen lines are 1.
- R7: While `inhibit` is 1, every line sits at its idle level, whatever the held code and whatever the level of `strobe`. The idle level is all 0 with `ACTIVE_LOW` = 0 and all 1 with `ACTIVE_LOW` = 1. This takes effect combinationally, without waiting for a clock edge.
- R8: While `inhibit` is 0, exactly one line is at its active level.
- R9: Inhibit does not alter the held code. When `inhibit` returns to 0, the held selection reappears with no new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the holding register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the held code |
| code_in | input | 4 | Binary select code; bit 3 is the most significant bit |
| strobe | input | 1 | Load enable; 1 lets the register follow `code_in`, 0 holds |
| inhibit | input | 1 | Forces all outputs to the idle level while 1 |
| sel_out | output | 16 | One line per code value, with polarity set by `ACTIVE_LOW` |

## Verification
The assertions assume that `strobe`, `inhibit` and `code_in` are synchronous to `clk` and settle before each rising edge. They also assume that reset is released away from a clock edge. The bench meets both conditions by changing every input on the falling edge and releasing reset on a falling edge. The hold and load properties compare `sel_out` between consecutive edges only when `inhibit` was low at both edges. Because of this, inhibit pulses in the stimulus can appear with the strobe in either state without breaking those properties.

// File: rtl/latched_decoder_pkg.sv
package latched_decoder_pkg;

    localparam int unsigned DEF_CODE_W = 4;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } polarity_e;

    function automatic int unsigned lines_for(input int unsigned code_w);
        return 32'd1 << code_w;
    endfunction

endpackage

// File: rtl/code_hold_reg.sv
module code_hold_reg #(
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] d,
    output logic [CODE_W-1:0] q
);

    // One storage bit per code bit, all sharing the same load control.
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else if (load) begin
                q[b] <= d[b];
            end
        end
    end

endmodule

// File: rtl/binary_onehot_dec.sv
module binary_onehot_dec #(
    parameter int unsigned CODE_W = 4,
    localparam int unsigned LINES = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [LINES-1:0]  hot
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign hot[i] = (code == CODE_W'(i));
    end

endmodule

// File: rtl/select_gate.sv
module select_gate #(
    parameter int unsigned LINES = 16,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic [LINES-1:0] hot,
    input  logic             inhibit,
    output logic [LINES-1:0] lines
);

    logic [LINES-1:0] gated;

    assign gated = inhibit ? '0 : hot;

    if (ACTIVE_LOW) begin : g_low
        assign lines = ~gated;
    end else begin : g_high
        assign lines = gated;
    end

endmodule

// File: rtl/latched_decoder.sv
module latched_decoder
    import latched_decoder_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W,
    parameter bit ACTIVE_LOW = 1'b0,
    localparam int unsigned LINES = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              strobe,
    input  logic              inhibit,
    output logic [LINES-1:0]  sel_out
);

    logic [CODE_W-1:0] held_code;
    logic [LINES-1:0]  hot;

    code_hold_reg #(
        .CODE_W(CODE_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe),
        .d     (code_in),
        .q     (held_code)
    );

    binary_onehot_dec #(
        .CODE_W(CODE_W)
    ) u_dec (
        .code (held_code),
        .hot  (hot)
    );

    select_gate #(
        .LINES      (LINES),
        .ACTIVE_LOW (ACTIVE_LOW)
    ) u_gate (
        .hot     (hot),
        .inhibit (inhibit),
        .lines   (sel_out)
    );

endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk #(
    parameter int unsigned CODE_W = 4,
    parameter bit ACTIVE_LOW = 1'b0,
    localparam int unsigned LINES = 1 << CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_in,
    input logic              strobe,
    input logic              inhibit,
    input logic [LINES-1:0]  sel_out
);

    logic [LINES-1:0] act;
    assign act = ACTIVE_LOW ? ~sel_out : sel_out;

    AST_INHIBIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (act == '0)); // R7

    AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |-> ($countones(act) == 1)); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(strobe) && $past(rst_n) && !inhibit && !$past(inhibit))
        |-> $stable(sel_out)); // R3

    AST_LOAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe) && $past(rst_n) && !inhibit)
        |-> (act == (LINES'(1) << $past(code_in)))); // R2 R4

endmodule

bind latched_decoder latched_decoder_chk #(
    .CODE_W     (CODE_W),
    .ACTIVE_LOW (ACTIVE_LOW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (code_in),
    .strobe  (strobe),
    .inhibit (inhibit),
    .sel_out (sel_out)
);

// File: tb/test_latched_decoder.sv
module test_latched_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 5000;
    localparam logic [3:0] CODES [16] = '{
        4'd5, 4'd0, 4'd15, 4'd9, 4'd2, 4'd12, 4'd7, 4'd1,
        4'd14, 4'd4, 4'd11, 4'd8, 4'd3, 4'd13, 4'd6, 4'd10
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  code_in;
    logic        strobe;
    logic        inhibit;
    logic [15:0] sel_hi;
    logic [15:0] sel_lo;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    latched_decoder #(.ACTIVE_LOW(1'b0)) i_latched_decoder (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .strobe(strobe),
        .inhibit(inhibit), .sel_out(sel_hi)
    );

    latched_decoder #(.ACTIVE_LOW(1'b1)) i_latched_decoder_n (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .strobe(strobe),
        .inhibit(inhibit), .sel_out(sel_lo)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Check both polarities for an addressed index, or for idle when idx < 0.
    task automatic chk_both(input int idx, input string req);
        logic [15:0] hot;
        hot = (idx < 0) ? 16'h0000 : (16'h0001 << idx);
        chk(sel_hi, hot, {req, " R5 high"});
        chk(sel_lo, ~hot, {req, " R6 low"});
    endtask

    initial begin
        rst_n = 1'b0; strobe = 1'b0; inhibit = 1'b0; code_in = 4'd9;
        repeat (2) @(negedge clk);
        chk_both(0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_both(0, "R1 after reset");

        // Table walk: every code in both polarities.
        for (int k = 0; k < 16; k++) begin
            code_in = CODES[k]; strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0; code_in = ~CODES[k];
            chk_both(int'(CODES[k]), "R2 R4 R8 table");
        end

        // Extremes of the code range.
        code_in = 4'b1111; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk_both(15, "R4 code 1111");
        code_in = 4'b0000; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk_both(0, "R4 code 0000");

        // Hold: data moves while strobe is low.
        code_in = 4'd10; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; code_in = 4'd3;
        @(negedge clk);
        code_in = 4'd7;
        @(negedge clk);
        chk_both(10, "R3 hold");

        // Inhibit with strobe low, then release.
        inhibit = 1'b1;
        #1;
        chk_both(-1, "R7 strobe low");
        @(negedge clk);
        inhibit = 1'b0;
        #1;
        chk_both(10, "R9 release");

        // Inhibit with strobe high: a new code loads underneath.
        @(negedge clk);
        inhibit = 1'b1; strobe = 1'b1; code_in = 4'd5;
        #1;
        chk_both(-1, "R7 strobe high");
        @(negedge clk);
        chk_both(-1, "R7 after load");
        strobe = 1'b0; inhibit = 1'b0;
        #1;
        chk_both(5, "R9 R2 loaded under inhibit");

        // Reset mid-run clears the held code.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_both(0, "R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_both(0, "R1 held after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule